// File: doc/BRIEF.md
# Command-Driven Variable-Length SPI Master

This block is a single-master SPI engine steered by one 8-bit command byte. The upper nibble of the byte picks the operation: an initialise command, or a receive or send transfer. Bit 6 also sets the clock idle level, and bit 7 decides which of two active-low chip selects is driven. The lower nibble gives the word length, from 1 to 16 bits, where the value zero means sixteen. Each command that starts a transfer also loads a 16-bit data word. The engine left-aligns that word so its first bit sits at the top of a 16-bit shift buffer. It then clocks the bits out on MOSI, MSB first, and shifts MISO into the bottom of the same buffer.

Bit timing comes from an internal tick. A free-running 8-bit timer restarts from a programmable reload value and counts up to its all-ones state, behind a power-of-two prescaler. Each data bit takes two ticks. After the final tick the engine releases the chip select and shows the received word right-justified. It also raises a transmit-done or receive-done flag.

Commands arrive on a valid/ready pair. `cmd_ready` is low for the whole of a transfer. A command offered during that time is not taken and has no effect on the transfer in flight. A source that keeps `cmd_valid` high is served once the transfer ends. The transfer word and the reload value are sampled only on the edge where a transfer command is accepted.

Top module: `spi_cmd_master`

## Requirements
- R1: After reset: `busy`, `init_done`, `cmd_err`, `tx_done`, `rx_done` and `sclk` are 0, both chip selects are 1, and `cmd_ready` is 1.
- R2: An accepted command with upper nibble 0x0 sets `init_done`, which then stays set. It starts no transfer: `busy` stays 0 and both chip selects stay high.
- R3: An accepted command whose upper nibble is not one of 0x0, 0x2, 0x6, 0xA or 0xE sets `cmd_err` on the accepting edge and starts nothing. Any accepted valid command clears `cmd_err`. `cmd_err` changes only on an accepting edge.
- R4: `cmd_ready` equals the inverse of `busy`. A command offered while `busy` is 1 is ignored: it does not change `init_done`, the chip selects or the data of the running transfer.
- R5: During a transfer of n bits, `sclk` starts at its idle level and makes exactly n rising edges. It is back at idle when `busy` falls. The idle level is command bit 6 (1 = high). A length field of 0 means n = 16.
- R6: A transfer with command bit 7 = 0 drives `cs_rx_n` low, and one with bit 7 = 1 drives `cs_tx_n` low. The line is low from the edge after acceptance until `busy` falls. The two lines are never low at the same time.
- R7: MOSI carries `tx_word[n-1:0]` MSB first. Each bit is held stable for the whole high phase of `sclk`, and the slave captures it on the rising edge.
- R8: MISO is sampled on each `sclk` rising edge. After completion, `rx_word` holds the n received bits right-justified, with the first bit received as the most significant and zeros above. It stays unchanged until the next transfer starts.
- R9: The tick period is T = 2^PRE_LOG2 × (256 − reload) clocks, counted from acceptance. `busy` is high for exactly (2n+1)·T clocks.
- R10: `tx_done` and `rx_done` are cleared when a transfer starts. On completion, `rx_done` is set for a bit-7-clear command and `tx_done` for a bit-7-set command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted (not busy) |
| cmd_byte | input | 8 | Opcode nibble and length nibble |
| tx_word | input | 16 | Right-justified word to send, sampled at acceptance |
| reload | input | 8 | Timer reload value, sampled at acceptance |
| miso | input | 1 | Serial data from slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| cs_rx_n | output | 1 | Chip select for receive commands, active low |
| cs_tx_n | output | 1 | Chip select for send commands, active low |
| rx_word | output | 16 | Received word, right-justified, held |
| init_done | output | 1 | Initialise command seen |
| busy | output | 1 | Transfer in progress |
| cmd_err | output | 1 | Last accepted command was invalid |
| tx_done | output | 1 | Send transfer completed |
| rx_done | output | 1 | Receive transfer completed |

## Verification
`init_done` and `cmd_err` change on the clock edge that accepts a command. `busy`, the chosen chip select and the idle `sclk` level appear on that same edge, so the bench reads all of them at the falling edge that follows. Completion comes (2n+1)·T clocks after acceptance. The bench counts falling edges while `busy` is high and compares the count with that product. It reads `rx_word`, the done flags and the released chip select only after `busy` is low. The bench's slave model detects each `sclk` rise at the next falling clock edge. It captures MOSI there and only then changes MISO, which keeps MISO stable around every sampling edge of the design.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int WORD_W = 16;
  localparam int LEN_W  = 4;
  localparam int NB_W   = $clog2(WORD_W) + 1;

  typedef enum logic [1:0] {OP_INIT, OP_XFER, OP_BAD} op_kind_e;

  typedef struct packed {
    op_kind_e          kind;
    logic              cpol;
    logic              is_tx;
    logic [NB_W-1:0]   nbits;
  } cmd_dec_t;

  function automatic cmd_dec_t decode_cmd(input logic [7:0] b);
    cmd_dec_t d;
    case (b[7:4])
      4'h0:                   d.kind = OP_INIT;
      4'h2, 4'h6, 4'hA, 4'hE: d.kind = OP_XFER;
      default:                d.kind = OP_BAD;
    endcase
    d.cpol  = b[6];
    d.is_tx = b[7];
    d.nbits = (b[LEN_W-1:0] == '0) ? NB_W'(WORD_W) : NB_W'(b[LEN_W-1:0]);
    return d;
  endfunction
endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int PRE_LOG2 = 1,
  parameter int RELOAD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  logic [RELOAD_W-1:0] reload,
  output logic                tick
);
  logic [RELOAD_W-1:0] tmr_q, reload_q;
  logic                pre_wrap;

  generate
    if (PRE_LOG2 == 0) begin : g_nopre
      assign pre_wrap = 1'b1;
    end else begin : g_pre
      logic [PRE_LOG2-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pre_q <= '0;
        else if (restart) pre_q <= '0;
        else              pre_q <= pre_q + 1'b1;
      end
      assign pre_wrap = &pre_q;
      // R9
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

  assign tick = pre_wrap && (&tmr_q) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q    <= '0;
      reload_q <= '0;
    end else if (restart) begin
      tmr_q    <= reload;
      reload_q <= reload;
    end else if (pre_wrap) begin
      tmr_q <= (&tmr_q) ? reload_q : tmr_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tick,
  input  logic              cpol,
  input  logic              is_tx,
  input  logic [NB_W-1:0]   nbits,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_rx_n,
  output logic              cs_tx_n,
  output logic [WORD_W-1:0] rx_word
);
  localparam int CNT_W = NB_W + 1;

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sh_q, aligned;

  assign aligned = tx_word << (NB_W'(WORD_W) - nbits);
  assign done    = busy && tick && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      cs_rx_n <= 1'b1;
      cs_tx_n <= 1'b1;
      rx_word <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      cnt_q   <= {nbits, 1'b0};
      sh_q    <= aligned;
      sclk    <= cpol;
      mosi    <= aligned[WORD_W-1];
      cs_rx_n <= is_tx;
      cs_tx_n <= !is_tx;
    end else if (busy && tick) begin
      if (cnt_q == '0) begin
        busy    <= 1'b0;
        cs_rx_n <= 1'b1;
        cs_tx_n <= 1'b1;
        rx_word <= sh_q;
      end else begin
        cnt_q <= cnt_q - 1'b1;
        if (!sclk) begin
          sclk <= 1'b1;
          sh_q <= {sh_q[WORD_W-2:0], miso};
        end else begin
          sclk <= 1'b0;
          mosi <= sh_q[WORD_W-1];
        end
      end
    end
  end

  // R5
  sclk_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !start) |=> $stable(sclk));
  // R7
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && sclk) |-> $stable(mosi));
  // R6
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!cs_rx_n, !cs_tx_n}));
  // R6
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_rx_n && cs_tx_n));
endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master
  import spi_cmd_pkg::*;
#(
  parameter int PRE_LOG2 = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [7:0]  cmd_byte,
  input  logic [15:0] tx_word,
  input  logic [7:0]  reload,
  input  logic        miso,
  output logic        sclk,
  output logic        mosi,
  output logic        cs_rx_n,
  output logic        cs_tx_n,
  output logic [15:0] rx_word,
  output logic        init_done,
  output logic        busy,
  output logic        cmd_err,
  output logic        tx_done,
  output logic        rx_done
);
  cmd_dec_t dec;
  logic     accept, start, tick, done;

  assign dec       = decode_cmd(cmd_byte);
  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign start     = accept && (dec.kind == OP_XFER);

  spi_tick_gen #(.PRE_LOG2(PRE_LOG2), .RELOAD_W(8)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(start), .reload(reload), .tick(tick)
  );

  spi_shift_core u_core (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
    .cpol(dec.cpol), .is_tx(dec.is_tx), .nbits(dec.nbits),
    .tx_word(tx_word), .miso(miso), .busy(busy), .done(done),
    .sclk(sclk), .mosi(mosi), .cs_rx_n(cs_rx_n), .cs_tx_n(cs_tx_n),
    .rx_word(rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_done <= 1'b0;
      cmd_err   <= 1'b0;
      tx_done   <= 1'b0;
      rx_done   <= 1'b0;
    end else begin
      if (accept) begin
        cmd_err <= (dec.kind == OP_BAD);
        if (dec.kind == OP_INIT) init_done <= 1'b1;
      end
      if (start) begin
        tx_done <= 1'b0;
        rx_done <= 1'b0;
      end else if (done) begin
        if (!cs_tx_n) tx_done <= 1'b1;
        if (!cs_rx_n) rx_done <= 1'b1;
      end
    end
  end

  // R3
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(cmd_err));
  // R4
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && !done) |=> (busy && $stable({cs_rx_n, cs_tx_n, init_done})));
  // R10
  flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !(tx_done || rx_done));
  // R2
  init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
endmodule

// File: tb/sim_spi_cmd_master.sv
`timescale 1ns/1ps
module sim_spi_cmd_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_byte = 8'h00;
  logic [15:0] tx_word = 16'h0000;
  logic [7:0]  reload = 8'hFF;
  logic        miso = 1'b0;
  logic        sclk, mosi, cs_rx_n, cs_tx_n;
  logic [15:0] rx_word;
  logic        init_done, busy, cmd_err, tx_done, rx_done;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  spi_cmd_master #(.PRE_LOG2(1)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_byte(cmd_byte), .tx_word(tx_word), .reload(reload), .miso(miso),
    .sclk(sclk), .mosi(mosi), .cs_rx_n(cs_rx_n), .cs_tx_n(cs_tx_n),
    .rx_word(rx_word), .init_done(init_done), .busy(busy), .cmd_err(cmd_err),
    .tx_done(tx_done), .rx_done(rx_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [7:0] b);
    cmd_byte  = b;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // One transfer with a bench slave; poke offers a command while busy.
  task automatic run_xfer(input logic [3:0] op, input logic [3:0] lf,
                          input logic [15:0] txw, input logic [15:0] pat,
                          input logic [7:0] rl, input bit poke);
    int n, tper, cyc, rises, cs_bad, rdy_bad;
    logic [15:0] cap, mask;
    logic cpol, prev, dir;
    n    = (lf == 4'd0) ? 16 : int'(lf);
    tper = 2 * (256 - int'(rl));
    cpol = op[2];
    dir  = op[3];
    mask = (n == 16) ? 16'hFFFF : 16'((1 << n) - 1);
    tx_word = txw;
    reload  = rl;
    miso    = pat[n-1];
    send_cmd({op, lf});
    chk("R1/R4 busy after accept", busy, 1);
    chk("R5 sclk idle at start", sclk, cpol);
    chk("R6 cs pair at start", {cs_rx_n, cs_tx_n}, dir ? 2'b10 : 2'b01);
    chk("R10 flags cleared at start", {tx_done, rx_done}, 0);
    chk("R3 err cleared by valid", cmd_err, 0);
    cyc = 0; rises = 0; cs_bad = 0; rdy_bad = 0; cap = '0; prev = cpol;
    while (busy && cyc < 20000) begin
      cyc++;
      if ({cs_rx_n, cs_tx_n} != (dir ? 2'b10 : 2'b01)) cs_bad++;
      if (cmd_ready) rdy_bad++;
      if (sclk && !prev) begin
        cap = {cap[14:0], mosi};
        rises++;
        if (rises < n) miso = pat[n-1-rises];
      end
      prev = sclk;
      if (poke) begin
        if (cyc == 4) begin cmd_byte = 8'h05; cmd_valid = 1'b1; end
        if (cyc == 7) cmd_valid = 1'b0;
      end
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk("R9 busy length", cyc, (2*n+1)*tper);
    chk("R5 rising edge count", rises, n);
    chk("R5 sclk idle at end", sclk, cpol);
    chk("R7 mosi bits", cap & mask, txw & mask);
    chk("R8 rx_word", rx_word, pat & mask);
    chk("R6 cs during transfer", cs_bad, 0);
    chk("R6 cs released", {cs_rx_n, cs_tx_n}, 2'b11);
    chk("R4 cmd_ready low while busy", rdy_bad, 0);
    chk("R10 done flags", {tx_done, rx_done}, dir ? 2'b10 : 2'b01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog actual=expired expected=finish");
    $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {busy, init_done, cmd_err, tx_done, rx_done, sclk}, 0);
    chk("R1 reset cs", {cs_rx_n, cs_tx_n}, 2'b11);
    chk("R1 reset ready", cmd_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: init command offered mid-transfer must be ignored
    run_xfer(4'hE, 4'd8, 16'h00B4, 16'h005A, 8'hFE, 1'b1);
    chk("R4 init ignored while busy", init_done, 0);

    // R2: init command
    send_cmd(8'h05);
    chk("R2 init_done set", init_done, 1);
    repeat (3) @(negedge clk);
    chk("R2 no transfer", {busy, cs_rx_n, cs_tx_n}, 3'b011);

    // R3: every non-transfer opcode
    for (int k = 0; k < 16; k++) begin
      logic [3:0] nib;
      nib = 4'(k);
      if (nib == 4'h2 || nib == 4'h6 || nib == 4'hA || nib == 4'hE) continue;
      send_cmd({nib, 4'h3});
      chk("R3 cmd_err per opcode", cmd_err, (nib != 4'h0));
      chk("R3 no transfer", {busy, cs_rx_n, cs_tx_n}, 3'b011);
    end
    chk("R2 init_done sticky", init_done, 1);

    // R5..R10: sweep opcodes, lengths and two reload values
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < 4; i++) begin
        for (int l = 0; l < 16; l++) begin
          logic [15:0] tw, pw;
          tw = 16'hA5C3 ^ 16'(l * 16'h1111) ^ 16'(i * 16'h0F0F);
          pw = 16'h3C96 ^ 16'(l * 16'h0707) ^ 16'(r * 16'hFFFF);
          run_xfer({2'(i), 2'b10}, 4'(l), tw, pw, r ? 8'hFD : 8'hFF, 1'b0);
        end
      end
    end

    // R8: rx_word held across a non-transfer command
    run_xfer(4'h2, 4'd4, 16'h0003, 16'h000D, 8'hFF, 1'b0);
    send_cmd(8'h3F);
    repeat (4) @(negedge clk);
    chk("R8 rx_word held", rx_word, 16'h000D);
    chk("R3 bad cmd flagged", cmd_err, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule